// File: doc/BRIEF.md
# Dual-Integer Issue Group Gate

This block decides, one candidate at a time, whether an already classified instruction can join the issue group being built for the current cycle of an in-order superscalar core. The core has two dedicated integer pipes, one memory port and one branch unit. Each candidate carries a class code. The gate answers accept or reject in the same cycle, and the answer depends on what the group already holds. The gate also reports when the group is closed to everything except no-resource entries.

All units are fully pipelined, so no occupancy carries over into the next cycle. The scheduler pulses the advance input to start a new group, and that pulse clears all held occupancy. The integer pipes that serve only shifts or only condition-code writers must be claimed before any generic integer op in a group. A flag set by the first generic op enforces this order.

Top module: `issue_group_gate`

## Requirements
- R1: After reset, and in the cycle after any advance pulse, the group is empty: `group_closed` is 0 and any class that needs an empty group is accepted.
- R2: When `cand_valid` is 1, exactly one of `take` and `refuse` is 1 in that same cycle. When it is 0, both are 0. An accepted candidate updates the state at the next rising clock edge.
- R3: At most two integer-class candidates (codes 1, 2 and 3) are accepted per group. A further integer candidate is refused.
- R4: A shift candidate (code 1) is accepted only when pipe 0 is unused, no generic integer op has been accepted and the integer limit is not reached. It then claims pipe 0.
- R5: A condition-code candidate (code 2) is accepted only when pipe 1 is unused, no generic integer op has been accepted and the integer limit is not reached. It then claims pipe 1.
- R6: A generic integer candidate (code 3) needs only room under the integer limit. Once one is accepted, later shift and condition-code candidates in the same group are refused.
- R7: A memory candidate (code 4) is accepted once per group, whatever integer ops the group holds.
- R8: A branch candidate (code 5) is accepted whenever the group is open. It closes the group, and `group_closed` rises at the next edge.
- R9: A serializing candidate (code 6) is accepted only into a completely empty group, and it closes the group.
- R10: A no-resource candidate (code 0) is always accepted, even into a closed group, and it leaves the group state unchanged.
- R11: When `advance` is 1, a candidate in the same cycle is refused, whatever its class, and the group becomes empty at the next edge.
- R12: Code 7 is not a valid class and is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate is presented this cycle |
| cand_class | input | 3 | Candidate class code |
| advance | input | 1 | Start a new issue group |
| take | output | 1 | Candidate accepted (combinational) |
| refuse | output | 1 | Candidate rejected (combinational) |
| group_closed | output | 1 | Current group accepts only no-resource entries |

## Verification
`take` and `refuse` are combinational, so they are due in the same cycle as the candidate. `group_closed` and every other effect of an acceptance are due one edge later. The bench drives each input on the falling edge and compares one time unit later. It updates its reference model only after that comparison, so the model's `closed` bit matches the register when the next step samples it. Random class, valid and advance streams are mixed with directed sequences that fill the integer slots, reach the ordering rule and close the group in both ways.

// File: rtl/issue_group_gate.sv
module issue_group_gate #(
  parameter int INT_SLOTS = 2,
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic [CLS_W-1:0] cand_class,
  input  logic             advance,
  output logic             take,
  output logic             refuse,
  output logic             group_closed
);
  localparam int CNT_W = $clog2(INT_SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INT_SLOTS);
  localparam logic [CLS_W-1:0] C_NONE  = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_SHIFT = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_CC    = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_GEN   = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_MEM   = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_BR    = CLS_W'(5);
  localparam logic [CLS_W-1:0] C_SER   = CLS_W'(6);

  logic             p0_busy, p1_busy, mem_busy, gen_seen, closed_q;
  logic [CNT_W-1:0] int_cnt;
  logic             int_room, empty, fits;

  assign int_room = int_cnt < CNT_MAX;
  assign empty    = !p0_busy && !p1_busy && !mem_busy && !gen_seen &&
                    int_cnt == '0 && !closed_q;

  always_comb begin
    unique case (cand_class)
      C_NONE:  fits = 1'b1;
      C_SHIFT: fits = !closed_q && !p0_busy && !gen_seen && int_room;
      C_CC:    fits = !closed_q && !p1_busy && !gen_seen && int_room;
      C_GEN:   fits = !closed_q && int_room;
      C_MEM:   fits = !closed_q && !mem_busy;
      C_BR:    fits = !closed_q;
      C_SER:   fits = empty;
      default: fits = 1'b0;
    endcase
  end

  assign take         = cand_valid && !advance && fits;
  assign refuse       = cand_valid && !take;
  assign group_closed = closed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || advance) begin
      p0_busy  <= 1'b0;
      p1_busy  <= 1'b0;
      mem_busy <= 1'b0;
      gen_seen <= 1'b0;
      closed_q <= 1'b0;
      int_cnt  <= '0;
    end else if (take) begin
      unique case (cand_class)
        C_SHIFT: begin p0_busy <= 1'b1; int_cnt <= int_cnt + 1'b1; end
        C_CC:    begin p1_busy <= 1'b1; int_cnt <= int_cnt + 1'b1; end
        C_GEN:   begin gen_seen <= 1'b1; int_cnt <= int_cnt + 1'b1; end
        C_MEM:   mem_busy <= 1'b1;
        C_BR, C_SER: closed_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> $onehot({take, refuse}));
  assert_silent_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> !take && !refuse);
  assert_int_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_cnt <= CNT_MAX);
  assert_branch_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cand_class == C_BR) |=> group_closed);
  assert_serial_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cand_class == C_SER) |=> group_closed);
  assert_closed_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (group_closed && take) |-> cand_class == C_NONE);
  assert_advance_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> !group_closed);
endmodule

// File: tb/issue_group_gate_test.sv
module issue_group_gate_test;
  logic clk = 1'b0, rst_n = 1'b0, cand_valid = 1'b0, advance = 1'b0;
  logic [2:0] cand_class = 3'd0;
  logic take, refuse, group_closed;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  bit m_p0, m_p1, m_mem, m_gen, m_closed;
  int m_cnt;

  always #2.5 clk = ~clk;

  issue_group_gate uut (.clk(clk), .rst_n(rst_n), .cand_valid(cand_valid),
    .cand_class(cand_class), .advance(advance), .take(take),
    .refuse(refuse), .group_closed(group_closed));

  function automatic bit accepts(input logic [2:0] c);
    bit open_int = !m_closed && m_cnt < 2;
    case (c)
      3'd0: return 1;
      3'd1: return open_int && !m_p0 && !m_gen;
      3'd2: return open_int && !m_p1 && !m_gen;
      3'd3: return open_int;
      3'd4: return !m_closed && !m_mem;
      3'd5: return !m_closed;
      3'd6: return !m_closed && !m_p0 && !m_p1 && !m_mem && !m_gen && m_cnt == 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c, input bit a);
    if (a) return "R11";
    case (c)
      3'd0: return "R10"; 3'd1: return "R4"; 3'd2: return "R5";
      3'd3: return "R6";  3'd4: return "R7"; 3'd5: return "R8";
      3'd6: return "R9";  default: return "R12";
    endcase
  endfunction

  task automatic clear_model();
    m_p0 = 0; m_p1 = 0; m_mem = 0; m_gen = 0; m_closed = 0; m_cnt = 0;
  endtask

  task automatic step(input bit v, input logic [2:0] c, input bit a, input string tag);
    bit t;
    logic [2:0] exp_v, got;
    @(negedge clk);
    cand_valid = v; cand_class = c; advance = a;
    #1;
    t = v && !a && accepts(c);
    exp_v = {t, v && !t, m_closed};
    got = {take, refuse, group_closed};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: take/refuse/closed actual %b expected %b (class %0d)", tag, got, exp_v, c);
    end
    if (a) clear_model();
    else if (t) case (c)
      3'd1: begin m_p0 = 1; m_cnt++; end
      3'd2: begin m_p1 = 1; m_cnt++; end
      3'd3: begin m_gen = 1; m_cnt++; end
      3'd4: m_mem = 1;
      3'd5, 3'd6: m_closed = 1;
      default: ;
    endcase
  endtask

  task automatic nxt(); step(0, 3'd0, 1, "R11"); endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, 3'd0, 0, "R1");
    step(1, 3'd6, 0, "R1");
    nxt();
    step(1, 3'd6, 0, "R1");
    nxt();
    step(1, 3'd1, 0, "R4"); step(1, 3'd1, 0, "R4"); step(1, 3'd2, 0, "R5");
    step(1, 3'd3, 0, "R3"); step(1, 3'd4, 0, "R7"); step(1, 3'd4, 0, "R7");
    step(1, 3'd6, 0, "R9"); step(1, 3'd5, 0, "R8"); step(1, 3'd1, 0, "R8");
    step(1, 3'd0, 0, "R10"); step(1, 3'd4, 0, "R10");
    nxt();
    step(1, 3'd3, 0, "R6"); step(1, 3'd1, 0, "R6"); step(1, 3'd2, 0, "R6");
    step(1, 3'd3, 0, "R3"); step(1, 3'd3, 0, "R3"); step(1, 3'd7, 0, "R12");
    nxt();
    step(1, 3'd2, 0, "R5"); step(1, 3'd2, 0, "R5"); step(1, 3'd1, 0, "R4");
    step(1, 3'd3, 0, "R3");
    nxt();
    step(1, 3'd0, 0, "R10"); step(1, 3'd6, 0, "R10"); step(1, 3'd5, 0, "R11");
    step(1, 3'd0, 1, "R11"); step(0, 3'd5, 0, "R2"); step(1, 3'd5, 1, "R11");
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 5) != 0;
      bit a = ($urandom % 7) == 0;
      logic [2:0] c = 3'($urandom % 8);
      step(v, c, a, v ? tag_of(c, a) : "R2");
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule